// File: doc/BRIEF.md
# Phase-Change Memory Bank Request Scheduler

This block schedules the work of one phase-change memory bank. Three request streams arrive at its inputs. Reads carry an address and a tag. Writes carry an address and a tag. Line preparation requests carry only a line address. Their job is to drive every cell of the line to the slow-to-reach state in advance. The scheduler holds each stream in its own in-order queue. It issues one operation at a time to a latency-only bank model and raises a one-cycle completion pulse when that operation finishes. The pulse carries the operation kind, the tag and the line address.

Reads are latency-critical and normally go first. Writes go second. Line preparation runs only when no read or write is waiting. A small table records which lines have finished preparation. When a write targets a recorded line, it needs only the fast transition and is timed with the short write latency. The table entry is consumed when that write completes. Any other write uses the long latency.

A read that arrives while a line preparation is running stops it. The same applies to a read that arrives during a long write when write cancellation is enabled. The stopped operation stays at the head of its queue and later runs again from the start. A write queue that fills up switches the scheduler into a write-drain mode until the queue drops below a high-water mark.

Top module: `pcm_bank_sched`

## Requirements
- R1: After reset the bank is idle (`bank_op` = 0), `done_valid` is low, and all three ready outputs are high.
- R2: While the write queue is not in drain mode, a waiting read is issued before any waiting write or line preparation.
- R3: A read occupies the bank for RD_LAT cycles. It then produces exactly one single-cycle completion with `done_kind` = 2'b01 and its own tag. A read pushed into an idle, empty scheduler completes RD_LAT+1 cycles after the push edge.
- R4: A write to a line with no preparation record occupies the bank for WR_LONG_LAT cycles and completes with `done_kind` = 2'b10 and its tag.
- R5: Line preparation is issued only when the read and write queues are both empty. It takes PS_LAT cycles and completes with `done_kind` = 2'b11, `done_tag` = 0 and the prepared line on `done_addr`. Its line is then recorded as prepared.
- R6: A write to a recorded line takes WR_SHORT_LAT cycles and removes the record, so a second write to the same line takes WR_LONG_LAT.
- R7: A read waiting while line preparation runs stops it at the next edge. The preparation completes only once, PS_LAT+1 cycles after that read completes.
- R8: With CANCEL_EN = 1 and outside drain mode, a read waiting during a long write aborts that write. The read is served. The write then reruns for its full WR_LONG_LAT and completes exactly once.
- R9: A short write is never cancelled by a read. The read completes RD_LAT+1 cycles after the write completes.
- R10: Requests of one class complete in arrival order.
- R11: When the write queue holds WQ_DEPTH entries, `wr_ready` is low and the queue never exceeds its depth. Writes are issued ahead of reads until fewer than WQ_HWM writes remain.
- R12: `bank_op` and `done_kind` share one encoding: 0 for idle, 1 for read, 2 for write, 3 for line preparation. The completion kind equals the operation that occupied the bank in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read queue has room |
| rd_addr | input | AW | Read line address |
| rd_tag | input | TW | Read request tag |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write queue has room |
| wr_addr | input | AW | Write line address |
| wr_tag | input | TW | Write request tag |
| ps_valid | input | 1 | Line preparation request present |
| ps_ready | output | 1 | Preparation queue has room |
| ps_addr | input | AW | Line to prepare |
| bank_op | output | 2 | Operation occupying the bank |
| done_valid | output | 1 | One-cycle completion pulse |
| done_kind | output | 2 | Kind of completed operation |
| done_tag | output | TW | Tag of completed request (0 for preparation) |
| done_addr | output | AW | Line address of completed operation |

## Verification
The bound checker watches several rules on every cycle. It compares the occupancy time of every completion against the latency allowed for its kind. It checks that completions are single pulses matching the preceding bank operation. It confirms that preparation is never started while reads or writes wait and that it steps aside when a read appears. It also checks that reads win an idle bank outside drain mode, that a full write queue forces a write, and that the write queue never overflows. Other behaviours only the directed scenarios can show, because they span several operations. These include consumption of a preparation record by the short write, and the rerun of an aborted write or preparation with exactly one completion. They also include arrival order within a class and the exact completion sequence as drain mode is entered and left.

// File: rtl/pcm_bank_sched.sv
module pcm_bank_sched #(
  parameter int AW           = 24,
  parameter int TW           = 8,
  parameter int RQ_DEPTH     = 8,
  parameter int WQ_DEPTH     = 32,
  parameter int WQ_HWM       = 24,
  parameter int PQ_DEPTH     = 16,
  parameter int PT_ENTRIES   = 16,
  parameter int RD_LAT       = 500,
  parameter int WR_LONG_LAT  = 4000,
  parameter int WR_SHORT_LAT = 500,
  parameter int PS_LAT       = 4000,
  parameter bit CANCEL_EN    = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  input  logic [TW-1:0] rd_tag,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_tag,
  input  logic          ps_valid,
  output logic          ps_ready,
  input  logic [AW-1:0] ps_addr,
  output logic [1:0]    bank_op,
  output logic          done_valid,
  output logic [1:0]    done_kind,
  output logic [TW-1:0] done_tag,
  output logic [AW-1:0] done_addr
);

  localparam int RQ_PW = (RQ_DEPTH > 1) ? $clog2(RQ_DEPTH) : 1;
  localparam int WQ_PW = (WQ_DEPTH > 1) ? $clog2(WQ_DEPTH) : 1;
  localparam int PQ_PW = (PQ_DEPTH > 1) ? $clog2(PQ_DEPTH) : 1;
  localparam int PT_PW = (PT_ENTRIES > 1) ? $clog2(PT_ENTRIES) : 1;
  localparam int RQ_CW = $clog2(RQ_DEPTH + 1);
  localparam int WQ_CW = $clog2(WQ_DEPTH + 1);
  localparam int PQ_CW = $clog2(PQ_DEPTH + 1);
  localparam int LAT_A = (RD_LAT > WR_LONG_LAT) ? RD_LAT : WR_LONG_LAT;
  localparam int LAT_B = (WR_SHORT_LAT > PS_LAT) ? WR_SHORT_LAT : PS_LAT;
  localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int CW = $clog2(LAT_MAX + 1);

  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_WR   = 2'd2;
  localparam logic [1:0] OP_PS   = 2'd3;

  logic [AW-1:0] rq_addr_m [RQ_DEPTH];
  logic [TW-1:0] rq_tag_m  [RQ_DEPTH];
  logic [AW-1:0] wq_addr_m [WQ_DEPTH];
  logic [TW-1:0] wq_tag_m  [WQ_DEPTH];
  logic [AW-1:0] pq_addr_m [PQ_DEPTH];
  logic [AW-1:0] pt_addr   [PT_ENTRIES];

  logic [RQ_PW-1:0] rq_wp, rq_rp;
  logic [WQ_PW-1:0] wq_wp, wq_rp;
  logic [PQ_PW-1:0] pq_wp, pq_rp;
  logic [RQ_CW-1:0] rq_cnt;
  logic [WQ_CW-1:0] wq_cnt;
  logic [PQ_CW-1:0] pq_cnt;

  logic [1:0]          op;
  logic [CW-1:0]       lat;
  logic                op_short;
  logic [AW-1:0]       op_addr;
  logic [TW-1:0]       op_tag;
  logic                urgent;
  logic [PT_ENTRIES-1:0] pt_v;
  logic [PT_ENTRIES-1:0] pt_match;
  logic [PT_PW-1:0]    pt_ptr;
  logic                pt_hit_head;

  logic [1:0]    nxt_op;
  logic [CW-1:0] nxt_lat;
  logic [AW-1:0] nxt_addr;
  logic [TW-1:0] nxt_tag;

  assign rd_ready = rq_cnt != RQ_CW'(RQ_DEPTH);
  assign wr_ready = wq_cnt != WQ_CW'(WQ_DEPTH);
  assign ps_ready = pq_cnt != PQ_CW'(PQ_DEPTH);
  assign bank_op  = op;

  wire rq_push = rd_valid && rd_ready;
  wire wq_push = wr_valid && wr_ready;
  wire pq_push = ps_valid && ps_ready;

  wire finish = (op != OP_IDLE) && (lat == '0);
  wire rq_pop = finish && (op == OP_RD);
  wire wq_pop = finish && (op == OP_WR);
  wire pq_pop = finish && (op == OP_PS);

  wire wq_hot = (wq_cnt == WQ_CW'(WQ_DEPTH)) ||
                (urgent && (wq_cnt >= WQ_CW'(WQ_HWM)));
  wire abort_ps  = !finish && (op == OP_PS) && (rq_cnt != '0);
  wire cancel_wr = CANCEL_EN && !finish && (op == OP_WR) && !op_short &&
                   (rq_cnt != '0) && !wq_hot;

  always_comb begin
    pt_hit_head = 1'b0;
    pt_match    = '0;
    for (int i = 0; i < PT_ENTRIES; i++) begin
      if (pt_v[i] && pt_addr[i] == wq_addr_m[wq_rp]) pt_hit_head = 1'b1;
      if (pt_v[i] && pt_addr[i] == op_addr) pt_match[i] = 1'b1;
    end
  end

  always_comb begin
    nxt_op   = OP_IDLE;
    nxt_lat  = '0;
    nxt_addr = '0;
    nxt_tag  = '0;
    if (wq_hot || (rq_cnt == '0 && wq_cnt != '0)) begin
      nxt_op   = OP_WR;
      nxt_lat  = pt_hit_head ? CW'(WR_SHORT_LAT - 1) : CW'(WR_LONG_LAT - 1);
      nxt_addr = wq_addr_m[wq_rp];
      nxt_tag  = wq_tag_m[wq_rp];
    end else if (rq_cnt != '0) begin
      nxt_op   = OP_RD;
      nxt_lat  = CW'(RD_LAT - 1);
      nxt_addr = rq_addr_m[rq_rp];
      nxt_tag  = rq_tag_m[rq_rp];
    end else if (pq_cnt != '0) begin
      nxt_op   = OP_PS;
      nxt_lat  = CW'(PS_LAT - 1);
      nxt_addr = pq_addr_m[pq_rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rq_push) begin
      rq_addr_m[rq_wp] <= rd_addr;
      rq_tag_m[rq_wp]  <= rd_tag;
    end
    if (wq_push) begin
      wq_addr_m[wq_wp] <= wr_addr;
      wq_tag_m[wq_wp]  <= wr_tag;
    end
    if (pq_push) pq_addr_m[pq_wp] <= ps_addr;
    if (pq_pop && pt_match == '0) pt_addr[pt_ptr] <= op_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_wp <= '0; rq_rp <= '0; rq_cnt <= '0;
      wq_wp <= '0; wq_rp <= '0; wq_cnt <= '0;
      pq_wp <= '0; pq_rp <= '0; pq_cnt <= '0;
    end else begin
      if (rq_push) rq_wp <= (rq_wp == RQ_PW'(RQ_DEPTH - 1)) ? '0 : rq_wp + 1'b1;
      if (rq_pop)  rq_rp <= (rq_rp == RQ_PW'(RQ_DEPTH - 1)) ? '0 : rq_rp + 1'b1;
      if (wq_push) wq_wp <= (wq_wp == WQ_PW'(WQ_DEPTH - 1)) ? '0 : wq_wp + 1'b1;
      if (wq_pop)  wq_rp <= (wq_rp == WQ_PW'(WQ_DEPTH - 1)) ? '0 : wq_rp + 1'b1;
      if (pq_push) pq_wp <= (pq_wp == PQ_PW'(PQ_DEPTH - 1)) ? '0 : pq_wp + 1'b1;
      if (pq_pop)  pq_rp <= (pq_rp == PQ_PW'(PQ_DEPTH - 1)) ? '0 : pq_rp + 1'b1;
      if (rq_push && !rq_pop) rq_cnt <= rq_cnt + 1'b1;
      else if (!rq_push && rq_pop) rq_cnt <= rq_cnt - 1'b1;
      if (wq_push && !wq_pop) wq_cnt <= wq_cnt + 1'b1;
      else if (!wq_push && wq_pop) wq_cnt <= wq_cnt - 1'b1;
      if (pq_push && !pq_pop) pq_cnt <= pq_cnt + 1'b1;
      else if (!pq_push && pq_pop) pq_cnt <= pq_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op         <= OP_IDLE;
      lat        <= '0;
      op_short   <= 1'b0;
      op_addr    <= '0;
      op_tag     <= '0;
      urgent     <= 1'b0;
      done_valid <= 1'b0;
      done_kind  <= OP_IDLE;
      done_tag   <= '0;
      done_addr  <= '0;
      pt_v       <= '0;
      pt_ptr     <= '0;
    end else begin
      urgent     <= wq_hot;
      done_valid <= finish;
      if (finish) begin
        done_kind <= op;
        done_tag  <= op_tag;
        done_addr <= op_addr;
      end
      if (finish || abort_ps || cancel_wr) begin
        op <= OP_IDLE;
      end else if (op == OP_IDLE && nxt_op != OP_IDLE) begin
        op       <= nxt_op;
        lat      <= nxt_lat;
        op_short <= (nxt_op == OP_WR) && pt_hit_head;
        op_addr  <= nxt_addr;
        op_tag   <= nxt_tag;
      end else if (op != OP_IDLE) begin
        lat <= lat - 1'b1;
      end
      if (pq_pop && pt_match == '0) begin
        pt_v[pt_ptr] <= 1'b1;
        pt_ptr <= (pt_ptr == PT_PW'(PT_ENTRIES - 1)) ? '0 : pt_ptr + 1'b1;
      end
      if (wq_pop) pt_v <= pt_v & ~pt_match;
    end
  end

endmodule

module pcm_bank_sched_chk #(
  parameter int WQ_DEPTH     = 32,
  parameter int WQ_HWM       = 24,
  parameter int WQ_CW        = 6,
  parameter int RD_LAT       = 500,
  parameter int WR_LONG_LAT  = 4000,
  parameter int WR_SHORT_LAT = 500,
  parameter int PS_LAT       = 4000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bank_op,
  input logic             done_valid,
  input logic [1:0]       done_kind,
  input logic             rq_nz,
  input logic [WQ_CW-1:0] wq_cnt
);

  int unsigned elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elapsed <= 0;
    else if (bank_op == 2'd0) elapsed <= 0;
    else elapsed <= elapsed + 1;
  end

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_kind == 2'd1) |-> elapsed == RD_LAT);

  p_write_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_kind == 2'd2) |->
      (elapsed == WR_LONG_LAT || elapsed == WR_SHORT_LAT));

  p_prep_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_kind == 2'd3) |-> elapsed == PS_LAT);

  p_prep_idle_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_op == 2'd0 && (rq_nz || wq_cnt != '0)) |=> bank_op != 2'd3);

  p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_op == 2'd0 && rq_nz && wq_cnt < WQ_CW'(WQ_HWM)) |=> bank_op == 2'd1);

  p_prep_yield_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_op == 2'd3 && rq_nz) |=> bank_op == 2'd0);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wq_cnt <= WQ_CW'(WQ_DEPTH));

  p_drain_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_op == 2'd0 && wq_cnt == WQ_CW'(WQ_DEPTH)) |=> bank_op == 2'd2);

  p_kind_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_kind != 2'd0 && done_kind == $past(bank_op)));

endmodule

bind pcm_bank_sched pcm_bank_sched_chk #(
  .WQ_DEPTH(WQ_DEPTH), .WQ_HWM(WQ_HWM), .WQ_CW(WQ_CW),
  .RD_LAT(RD_LAT), .WR_LONG_LAT(WR_LONG_LAT),
  .WR_SHORT_LAT(WR_SHORT_LAT), .PS_LAT(PS_LAT)
) chk (
  .clk(clk), .rst_n(rst_n), .bank_op(bank_op), .done_valid(done_valid),
  .done_kind(done_kind), .rq_nz(rq_cnt != '0), .wq_cnt(wq_cnt)
);

// File: tb/pcm_bank_sched_test.sv
module pcm_bank_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, TW = 4;
  localparam int RD = 10, WL = 80, WS = 12, PS = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_valid = 0, wr_valid = 0, ps_valid = 0;
  logic [AW-1:0] rd_addr = 0, wr_addr = 0, ps_addr = 0;
  logic [TW-1:0] rd_tag = 0, wr_tag = 0;
  logic rd_ready, wr_ready, ps_ready, done_valid;
  logic [1:0] bank_op, done_kind;
  logic [TW-1:0] done_tag;
  logic [AW-1:0] done_addr;

  int checks = 0, fails = 0, cyc = 0, nlog = 0;
  logic [1:0]    lk [64];
  logic [TW-1:0] lt [64];
  logic [AW-1:0] la [64];
  int            lc [64];

  pcm_bank_sched #(.AW(AW), .TW(TW), .RQ_DEPTH(4), .WQ_DEPTH(4), .WQ_HWM(2),
    .PQ_DEPTH(4), .PT_ENTRIES(4), .RD_LAT(RD), .WR_LONG_LAT(WL),
    .WR_SHORT_LAT(WS), .PS_LAT(PS), .CANCEL_EN(1'b1)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (done_valid && nlog < 64) begin
    lk[nlog] = done_kind; lt[nlog] = done_tag; la[nlog] = done_addr;
    lc[nlog] = cyc; nlog++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_log(input int k);
    while (nlog < k) @(negedge clk);
  endtask

  task automatic push(input bit r, input bit w, input bit p,
                      input int ra, input int rt, input int wa, input int wt,
                      input int pa, output int pc);
    rd_valid = r; rd_addr = AW'(ra); rd_tag = TW'(rt);
    wr_valid = w; wr_addr = AW'(wa); wr_tag = TW'(wt);
    ps_valid = p; ps_addr = AW'(pa);
    @(negedge clk);
    rd_valid = 0; wr_valid = 0; ps_valid = 0;
    pc = cyc;
  endtask

  task automatic t_reset();
    chk(bank_op == 2'd0, "R1 bank_op", bank_op, 0);
    chk(!done_valid, "R1 done_valid", done_valid, 0);
    chk(rd_ready && wr_ready && ps_ready, "R1 ready", {rd_ready, wr_ready, ps_ready}, 7);
  endtask

  task automatic t_read();
    int b = nlog, p;
    push(1, 0, 0, 5, 3, 0, 0, 0, p);
    wait_log(b + 1);
    chk(lk[b] == 2'd1, "R12 read kind", lk[b], 1);
    chk(lt[b] == 3, "R3 read tag", lt[b], 3);
    chk(lc[b] - p == RD + 1, "R3 read latency", lc[b] - p, RD + 1);
    step(2);
  endtask

  task automatic t_long_write();
    int b = nlog, p;
    push(0, 1, 0, 0, 0, 9, 1, 0, p);
    wait_log(b + 1);
    chk(lk[b] == 2'd2 && lt[b] == 1, "R4 write kind/tag", lk[b], 2);
    chk(lc[b] - p == WL + 1, "R4 long latency", lc[b] - p, WL + 1);
    step(2);
  endtask

  task automatic t_priority();
    int b = nlog, p;
    push(1, 1, 1, 1, 1, 2, 2, 3, p);
    wait_log(b + 3);
    chk(lk[b] == 2'd1, "R2 read first", lk[b], 1);
    chk(lk[b+1] == 2'd2, "R2 write second", lk[b+1], 2);
    chk(lk[b+2] == 2'd3 && la[b+2] == 3 && lt[b+2] == 0, "R5 prep last addr", la[b+2], 3);
    step(2);
  endtask

  task automatic t_short_write();
    int b = nlog, p;
    push(0, 0, 1, 0, 0, 0, 0, 20, p);
    wait_log(b + 1);
    chk(lk[b] == 2'd3 && lc[b] - p == PS + 1, "R5 prep latency", lc[b] - p, PS + 1);
    step(2);
    push(0, 1, 0, 0, 0, 20, 4, 0, p);
    wait_log(b + 2);
    chk(lc[b+1] - p == WS + 1, "R6 short write", lc[b+1] - p, WS + 1);
    step(2);
    push(0, 1, 0, 0, 0, 20, 5, 0, p);
    wait_log(b + 3);
    chk(lc[b+2] - p == WL + 1, "R6 record consumed", lc[b+2] - p, WL + 1);
    step(2);
  endtask

  task automatic t_prep_abort();
    int b = nlog, p;
    push(0, 0, 1, 0, 0, 0, 0, 30, p);
    step(20);
    push(1, 0, 0, 31, 7, 0, 0, 0, p);
    wait_log(b + 2);
    step(PS + 10);
    chk(nlog == b + 2, "R7 single prep done", nlog - b, 2);
    chk(lk[b] == 2'd1 && lc[b] - p == RD + 2, "R7 read latency", lc[b] - p, RD + 2);
    chk(lk[b+1] == 2'd3 && lc[b+1] - lc[b] == PS + 1, "R7 prep restart", lc[b+1] - lc[b], PS + 1);
  endtask

  task automatic t_cancel();
    int b = nlog, p;
    push(0, 1, 0, 0, 0, 40, 2, 0, p);
    step(20);
    push(1, 0, 0, 41, 4, 0, 0, 0, p);
    wait_log(b + 2);
    step(WL + 10);
    chk(nlog == b + 2, "R8 single write done", nlog - b, 2);
    chk(lk[b] == 2'd1 && lc[b] - p == RD + 2, "R8 read served", lc[b] - p, RD + 2);
    chk(lk[b+1] == 2'd2 && lc[b+1] - lc[b] == WL + 1, "R8 write redone", lc[b+1] - lc[b], WL + 1);
  endtask

  task automatic t_short_no_cancel();
    int b = nlog, p, pw;
    push(0, 0, 1, 0, 0, 0, 0, 50, p);
    wait_log(b + 1);
    step(2);
    push(0, 1, 0, 0, 0, 50, 5, 0, pw);
    push(1, 0, 0, 51, 6, 0, 0, 0, p);
    wait_log(b + 3);
    chk(lk[b+1] == 2'd2 && lc[b+1] - pw == WS + 1, "R9 short write kept", lc[b+1] - pw, WS + 1);
    chk(lk[b+2] == 2'd1 && lc[b+2] - lc[b+1] == RD + 1, "R9 read after", lc[b+2] - lc[b+1], RD + 1);
    step(2);
  endtask

  task automatic t_order();
    int b = nlog, p;
    push(1, 0, 0, 1, 1, 0, 0, 0, p);
    push(1, 0, 0, 2, 2, 0, 0, 0, p);
    push(1, 0, 0, 3, 3, 0, 0, 0, p);
    wait_log(b + 3);
    for (int i = 0; i < 3; i++)
      chk(lt[b+i] == TW'(i + 1), "R10 arrival order", lt[b+i], i + 1);
    step(2);
  endtask

  task automatic t_drain();
    int b = nlog, p;
    int exp_k [6] = '{2, 2, 2, 1, 1, 2};
    int exp_t [6] = '{10, 11, 12, 8, 9, 13};
    for (int i = 0; i < 4; i++) push(0, 1, 0, 0, 0, 60 + i, 10 + i, 0, p);
    chk(!wr_ready, "R11 full wr_ready", wr_ready, 0);
    step(1);
    push(1, 0, 0, 70, 8, 0, 0, 0, p);
    push(1, 0, 0, 71, 9, 0, 0, 0, p);
    wait_log(b + 6);
    for (int i = 0; i < 6; i++) begin
      chk(lk[b+i] == 2'(exp_k[i]), "R11 drain kind", lk[b+i], exp_k[i]);
      chk(lt[b+i] == TW'(exp_t[i]), "R11 drain tag", lt[b+i], exp_t[i]);
    end
    chk(wr_ready, "R11 ready again", wr_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_read();
    t_long_write();
    t_priority();
    t_short_write();
    t_prep_abort();
    t_cancel();
    t_short_no_cancel();
    t_order();
    t_drain();
    summary();
  end
endmodule